// File: doc/BRIEF.md
# Bit-Masked GPIO Data Port

This block is an eight-line general-purpose I/O port that sits on a simple memory-mapped register bus. The bus has an address, a write enable, byte-wide write data and read data. The port holds two registers: a direction register, which makes each line an output or an input, and an output data register, which holds the value driven on each output line. Each line's output enable is its direction bit.

Accesses to the data window are qualified bit by bit by the address. Address bits [9:2] act as a pin mask, so software can set, clear or sample any subset of lines in one bus access, without a read-modify-write sequence. A data write only changes an output value if the line is configured as an output at that moment. A write to an input line is dropped, so software must write the value again after it turns the line into an output.

The input lines pass through a multi-stage synchronizer. The synchronized levels feed the read path, and they are also brought out for neighbouring logic such as an edge or level detector. On a data read, an output line returns the value it drives, and an input line returns its synchronized level.

Top module: `gmp_top`

## Requirements
- R1: After reset, the direction register and the output data register are both zero: `pin_oe` and `pin_out` read 0x00, and a read of the direction register returns 0x00.
- R2: A write to byte offset 0x400 loads the direction register. A direction bit of 1 makes that line an output, and `pin_oe` equals the direction register from the clock edge that takes the write. A read at 0x400 returns the direction register. Address bits [1:0] are ignored for every access.
- R3: A write in the data window (offsets 0x000 to 0x3FF) updates output bit n only when address bit n+2 is 1. Every other output bit keeps its value.
- R4: A data write leaves the stored value of a line that is currently an input unchanged. After that line becomes an output, it drives its earlier stored value until the line is written again.
- R5: On a data read, every bit whose mask bit (address bit n+2) is 0 reads as 0.
- R6: On a data read, a selected output line returns its driven value, and a selected input line returns its synchronized input level.
- R7: A change on `pin_in` appears on `pin_sync` and in data reads after exactly two rising clock edges, and not after one.
- R8: Reads of any offset outside the data window and the direction register return 0x00. Writes to such offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` and register state |
| pin_in | input | 8 | Asynchronous pin input levels |
| pin_out | output | 8 | Output values driven to the pads |
| pin_oe | output | 8 | Per-line output enable (1 = drive) |
| pin_sync | output | 8 | Synchronized input levels, for neighbouring logic |

## Verification
Register writes take effect at the rising edge that sees `bus_we`. The bench therefore drives every access on a falling edge and checks `pin_out`, `pin_oe` and register readback at the next falling edge, one edge later. Read data is combinational, so the bench compares it a short delay after it applies the address, with no clock edge in between. Input levels need two edges. The synchronizer test changes `pin_in` on a falling edge and checks `pin_sync` and the data readback after one edge, where the old value must still show, and again after the second edge, where the new value must show.

// File: rtl/gmp_pkg.sv
package gmp_pkg;

   // Register selected by the current bus address
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2
   } gmp_sel_e;

endpackage

// File: rtl/gmp_decode.sv
module gmp_decode
   import gmp_pkg::*;
#(
   parameter int NUM_PINS   = 8,
   parameter int ADDR_W     = 12,
   parameter int MASK_LSB   = 2,
   parameter int DIR_OFFSET = 'h400
) (
   input  logic [ADDR_W-1:0]   addr,
   output gmp_sel_e            sel,
   output logic [NUM_PINS-1:0] mask
);

   localparam int WIN_BITS = MASK_LSB + NUM_PINS;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

   // elaboration-time parameter checks
   if (MASK_LSB < 1) begin : g_bad_lsb
      $error("gmp_decode: MASK_LSB must be at least 1");
   end
   if (ADDR_W <= WIN_BITS) begin : g_bad_aw
      $error("gmp_decode: ADDR_W must exceed MASK_LSB + NUM_PINS");
   end
   if (DIR_OFFSET < (1 << WIN_BITS)) begin : g_bad_dir
      $error("gmp_decode: direction register overlaps the data window");
   end

   logic in_window;
   logic is_dir;
   logic unused_low;

   // the byte lane bits never take part in decoding
   assign unused_low = ^addr[MASK_LSB-1:0];

   assign in_window = (addr[ADDR_W-1:WIN_BITS] == '0);
   assign is_dir    = (addr[ADDR_W-1:MASK_LSB] == DIR_ADDR[ADDR_W-1:MASK_LSB]);

   always_comb begin
      if (in_window)   sel = SEL_DATA;
      else if (is_dir) sel = SEL_DIR;
      else             sel = SEL_NONE;
   end

   assign mask = in_window ? addr[MASK_LSB +: NUM_PINS] : '0;

endmodule

// File: rtl/gmp_sync.sv
module gmp_sync #(
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SYNC_RESET  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] d_async,
   output logic [NUM_PINS-1:0] q_sync
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gmp_sync: at least two stages are required");
   end

   logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      logic [NUM_PINS-1:0] stage_d;
      if (s == 0) begin : g_first
         assign stage_d = d_async;
      end else begin : g_next
         assign stage_d = stage_q[s-1];
      end

      if (SYNC_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            stage_q[s] <= stage_d;
         end
      end
   end

   assign q_sync = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/gmp_regs.sv
module gmp_regs
   import gmp_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  gmp_sel_e            sel,
   input  logic [NUM_PINS-1:0] mask,
   input  logic [NUM_PINS-1:0] wdata,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] out_q
);

   logic                dir_wr;
   logic                data_wr;
   logic [NUM_PINS-1:0] bit_wr;

   assign dir_wr  = we && (sel == SEL_DIR);
   assign data_wr = we && (sel == SEL_DATA);

   // a data bit changes only when addressed and configured as output
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
      assign bit_wr[i] = data_wr && mask[i] && dir_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_q[i] <= 1'b0;
            out_q[i] <= 1'b0;
         end else begin
            if (dir_wr)    dir_q[i] <= wdata[i];
            if (bit_wr[i]) out_q[i] <= wdata[i];
         end
      end
   end

   logic [NUM_PINS-1:0] addr_mask;
   assign addr_mask = (we && sel == SEL_DATA) ? mask : '0;

   AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((out_q ^ $past(out_q)) & ~$past(addr_mask)) == '0); // R3

   AST_INPUT_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0); // R4

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!we || sel == SEL_NONE) |=> ($stable(out_q) && $stable(dir_q))); // R8

endmodule

// File: rtl/gmp_rdmux.sv
module gmp_rdmux
   import gmp_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  gmp_sel_e            sel,
   input  logic [NUM_PINS-1:0] mask,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] out_q,
   input  logic [NUM_PINS-1:0] in_sync,
   output logic [NUM_PINS-1:0] rdata
);

   logic [NUM_PINS-1:0] level;

   // outputs read back what they drive, inputs read the synchronized pad
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_level
      assign level[i] = dir_q[i] ? out_q[i] : in_sync[i];
   end

   always_comb begin
      unique case (sel)
         SEL_DATA: rdata = level & mask;
         SEL_DIR:  rdata = dir_q;
         default:  rdata = '0;
      endcase
   end

   AST_READ_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_DATA) |-> ((rdata & ~mask) == '0)); // R5

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (rdata == '0)); // R8

endmodule

// File: rtl/gmp_top.sv
module gmp_top
   import gmp_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int ADDR_W      = 12,
   parameter int MASK_LSB    = 2,
   parameter int DIR_OFFSET  = 'h400,
   parameter int SYNC_STAGES = 2,
   parameter bit SYNC_RESET  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [NUM_PINS-1:0] bus_wdata,
   output logic [NUM_PINS-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_sync
);

   gmp_sel_e            sel;
   logic [NUM_PINS-1:0] mask;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] out_q;
   logic [NUM_PINS-1:0] in_sync;

   gmp_decode #(
      .NUM_PINS   (NUM_PINS),
      .ADDR_W     (ADDR_W),
      .MASK_LSB   (MASK_LSB),
      .DIR_OFFSET (DIR_OFFSET)
   ) u_decode (
      .addr (bus_addr),
      .sel  (sel),
      .mask (mask)
   );

   gmp_regs #(
      .NUM_PINS (NUM_PINS)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we),
      .sel   (sel),
      .mask  (mask),
      .wdata (bus_wdata),
      .dir_q (dir_q),
      .out_q (out_q)
   );

   gmp_sync #(
      .NUM_PINS    (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES),
      .SYNC_RESET  (SYNC_RESET)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (in_sync)
   );

   gmp_rdmux #(
      .NUM_PINS (NUM_PINS)
   ) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .mask    (mask),
      .dir_q   (dir_q),
      .out_q   (out_q),
      .in_sync (in_sync),
      .rdata   (bus_rdata)
   );

   assign pin_out  = out_q;
   assign pin_oe   = dir_q;
   assign pin_sync = in_sync;

endmodule

// File: tb/gmp_top_tb.sv
`timescale 1ns/1ps
module gmp_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic [7:0]  pin_oe;
   logic [7:0]  pin_sync;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gmp_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .pin_sync  (pin_sync)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, taken at the next rising edge, idle at the one after
   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 12'hFFC;
   endtask

   task automatic rd(input logic [11:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [11:0] maddr(input logic [7:0] m);
      return {2'b00, m, 2'b00};
   endfunction

   task automatic t_reset();
      logic [7:0] r;
      check("R1", "pin_oe after reset", pin_oe, 8'h00);
      check("R1", "pin_out after reset", pin_out, 8'h00);
      rd(12'h400, r);
      check("R1", "direction readback after reset", r, 8'h00);
   endtask

   task automatic t_direction();
      logic [7:0] r;
      wr(12'h400, 8'hA5);
      check("R2", "pin_oe follows direction", pin_oe, 8'hA5);
      rd(12'h400, r);
      check("R2", "direction readback", r, 8'hA5);
      rd(12'h403, r);
      check("R2", "low address bits ignored", r, 8'hA5);
   endtask

   task automatic t_masked_write();
      wr(12'h400, 8'hFF);
      wr(maddr(8'hFF), 8'h00);
      check("R3", "full-mask clear", pin_out, 8'h00);
      wr(maddr(8'h0F), 8'hFF);
      check("R3", "low-nibble mask", pin_out, 8'h0F);
      wr(maddr(8'h81), 8'h80);
      check("R3", "mask 0x81", pin_out, 8'h8E);
      wr(maddr(8'h00), 8'hFF);
      check("R3", "empty mask", pin_out, 8'h8E);
   endtask

   task automatic t_masked_read();
      logic [7:0] r;
      rd(maddr(8'h0C), r);
      check("R5", "read mask 0x0C", r, 8'h0C);
      rd(maddr(8'h80), r);
      check("R5", "read mask 0x80", r, 8'h80);
      rd(maddr(8'h71), r);
      check("R5", "read mask 0x71", r, 8'h00);
   endtask

   task automatic t_input_ignore();
      wr(12'h400, 8'h0F);
      wr(maddr(8'hFF), 8'h7F);
      check("R4", "only output lines take the write", pin_out, 8'h8F);
      wr(12'h400, 8'hFF);
      check("R4", "switched lines drive the old value", pin_out, 8'h8F);
      wr(maddr(8'hF0), 8'h70);
      check("R4", "rewrite after switching", pin_out, 8'h7F);
   endtask

   task automatic t_mixed_read();
      logic [7:0] r;
      wr(12'h400, 8'hF0);
      @(negedge clk);
      pin_in = 8'h5A;
      repeat (3) @(negedge clk);
      rd(maddr(8'hFF), r);
      check("R6", "mixed direction read", r, 8'h7A);
   endtask

   task automatic t_sync();
      logic [7:0] r;
      wr(12'h400, 8'h00);
      @(negedge clk);
      pin_in = 8'h00;
      repeat (3) @(negedge clk);
      pin_in = 8'h3C;
      @(negedge clk);
      check("R7", "pin_sync after one edge", pin_sync, 8'h00);
      rd(maddr(8'hFF), r);
      check("R7", "readback after one edge", r, 8'h00);
      @(negedge clk);
      check("R7", "pin_sync after two edges", pin_sync, 8'h3C);
      rd(maddr(8'hFF), r);
      check("R7", "readback after two edges", r, 8'h3C);
   endtask

   task automatic t_unmapped();
      logic [7:0] r;
      wr(12'h400, 8'hFF);
      wr(maddr(8'hFF), 8'h5A);
      rd(12'h404, r);
      check("R8", "read 0x404", r, 8'h00);
      rd(12'h800, r);
      check("R8", "read 0x800", r, 8'h00);
      rd(12'hFFC, r);
      check("R8", "read 0xFFC", r, 8'h00);
      wr(12'h800, 8'h00);
      wr(12'hC04, 8'h00);
      check("R8", "pin_out after unmapped writes", pin_out, 8'h5A);
      check("R8", "pin_oe after unmapped writes", pin_oe, 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direction();
      t_masked_write();
      t_masked_read();
      t_input_ignore();
      t_mixed_read();
      t_sync();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule